// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic and logic stage of a small 8-bit accumulator processor. Each cycle it takes an opcode byte, the present accumulator value and one second operand. The caller fetches that operand from a register, from memory or from the instruction stream. From the opcode alone the block works out which operation to run, which operand to use, where the result goes and which condition flags that class of instruction may change.

The result and its write enables come out combinationally in the same cycle. The five condition flags (sign, zero, auxiliary carry, parity, carry) sit in a register inside the block. That register is loaded on a rising clock edge while the caller holds the flag strobe high. The rest of the processor reads the flags through an 8-bit flag byte. The outputs tell the caller whether to write the result to the accumulator or to the register (or memory byte) named by an increment or decrement.

Top module: `acc_alu_core`

## Requirements
- R1: A synchronous active-high reset clears all five flags. The flag byte packs sign in bit 7, zero in bit 6, auxiliary carry in bit 4, parity in bit 2 and carry in bit 0. Bit 1 reads 1 and bits 3 and 5 read 0, so the byte after reset is 0x02.
- R2: Opcodes 0x80 to 0xBF form the register group. Bits 5:3 pick the operation: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 XOR, 6 OR, 7 compare. Bits 2:0 pick the operand. Code 7 uses acc_in itself and ignores the operand input. Every other code, including 6 (memory byte), uses the operand input.
- R3: Opcodes 0xC6, 0xCE, 0xD6, 0xDE, 0xE6, 0xEE, 0xF6 and 0xFE run the same eight operations, in the same order, on the operand input as an immediate byte.
- R4: Add and add-with-carry set carry to the carry out of bit 7 and auxiliary carry to the carry out of bit 3. Subtract, subtract-with-borrow and compare set carry to the borrow out of bit 7 and auxiliary carry to the borrow into bit 4. Only the with-carry and with-borrow forms take in the old carry.
- R5: Every flag-updating result sets sign to bit 7, sets zero when the result is 0x00, and sets parity when the result has an even number of ones.
- R6: AND, XOR and OR clear both carry and auxiliary carry.
- R7: Compare updates the flags exactly as a subtraction would. res_out shows the difference, but acc_we stays low.
- R8: Opcode 00rrr100 increments and 00rrr101 decrements the byte selected by rrr (7 means acc_in, any other code means the operand input). acc_we is raised when rrr is 7 and oth_we otherwise. Sign, zero, parity and auxiliary carry update, and carry keeps its value.
- R9: 0x07 rotates left with bit 7 going to both bit 0 and carry. 0x0F rotates right with bit 0 going to both bit 7 and carry. 0x17 rotates left through carry and 0x1F rotates right through carry. Only the carry flag changes.
- R10: 0x37 sets carry and 0x3F inverts it. No other flag changes, no write enable is raised, and res_out equals acc_in.
- R11: 0x27 decimal-adjusts the accumulator. It adds 0x06 when the low nibble exceeds 9 or auxiliary carry is set, and auxiliary carry becomes the carry out of bit 3 of that addition. It then adds 0x60 when the high nibble exceeds 9 or carry is set, or when the first addition carried out. Carry becomes set if it was set before or if either addition carries out.
- R12: res_out, acc_we, oth_we and op_ok follow the inputs in the same cycle. The flag byte changes only after a rising edge at which flag_strobe is high. With the strobe low it holds its value.
- R13: Any opcode outside the classes above drives op_ok low and both write enables low, and makes res_out equal acc_in. A strobe with such an opcode leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 8 | Instruction byte |
| acc_in | input | 8 | Current accumulator value |
| operand | input | 8 | Register, memory or immediate byte from the caller |
| flag_strobe | input | 1 | Load the flag register at this edge |
| res_out | output | 8 | Operation result |
| acc_we | output | 1 | Write res_out to the accumulator |
| oth_we | output | 1 | Write res_out to the register named by bits 5:3 |
| op_ok | output | 1 | Opcode belongs to a handled class |
| flags_out | output | 8 | Packed flag byte |

## Verification
The result, op_ok and both write enables are combinational, so they are due one time step after the inputs change. The bench drives the inputs on the falling edge and samples these outputs shortly after, before the next rising edge. The flag byte is due one rising edge later. The bench samples it at the following falling edge and also confirms that, before that edge, it still holds the old value. Each table vector starts from a known flag state: an XOR of a zero accumulator with itself, followed by a set-carry when the vector needs carry high. This keeps every flag a vector leaves untouched predictable.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DW  = 8;
    localparam int NW  = DW / 2;
    localparam int SW  = 3;
    localparam int NFL = 5;

    localparam logic [SW-1:0] SEL_ACC = 3'd7;
    localparam logic [NW-1:0] BCD_MAX = 4'd9;
    localparam logic [DW-1:0] LO_FIX  = 8'h06;
    localparam logic [DW-1:0] HI_FIX  = 8'h60;

    typedef enum logic [2:0] {
        OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_AND, OP_XOR, OP_OR, OP_CMP
    } alu_op_e;

    typedef enum logic [2:0] {
        CL_NONE, CL_ALU, CL_INC, CL_DEC, CL_ROT, CL_DAA, CL_SETC, CL_CPLC
    } cls_e;

    typedef enum logic [1:0] {
        RT_LC, RT_RC, RT_AL, RT_AR
    } rot_e;

    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic cy;
    } flags_t;

    typedef struct packed {
        cls_e          cls;
        alu_op_e       op;
        rot_e          rot;
        logic [SW-1:0] sel;
        logic          use_acc;
    } dec_t;

    function automatic logic [DW-1:0] pack_flags(input flags_t f);
        return {f.s, f.z, 1'b0, f.ac, 1'b0, f.p, 1'b1, f.cy};
    endfunction

    function automatic flags_t mask_for(input cls_e c);
        flags_t m;
        case (c)
            CL_ALU, CL_DAA:           m = '{s: 1'b1, z: 1'b1, ac: 1'b1, p: 1'b1, cy: 1'b1};
            CL_INC, CL_DEC:           m = '{s: 1'b1, z: 1'b1, ac: 1'b1, p: 1'b1, cy: 1'b0};
            CL_ROT, CL_SETC, CL_CPLC: m = '{s: 1'b0, z: 1'b0, ac: 1'b0, p: 1'b0, cy: 1'b1};
            default:                  m = '0;
        endcase
        return m;
    endfunction

    function automatic logic even_ones(input logic [DW-1:0] v);
        return ~(^v);
    endfunction

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
    import acc_alu_pkg::*;
(
    input  logic [DW-1:0] op,
    output dec_t          d
);
    logic [1:0]    grp;
    logic [2:0]    mid;
    logic [2:0]    low;

    assign grp = op[7:6];
    assign mid = op[5:3];
    assign low = op[2:0];

    always_comb begin
        d         = '0;
        d.cls     = CL_NONE;
        d.op      = alu_op_e'(mid);
        d.rot     = rot_e'(mid[1:0]);
        d.sel     = SEL_ACC;
        d.use_acc = 1'b1;
        unique case (grp)
            2'b10: begin
                d.cls     = CL_ALU;
                d.sel     = low;
                d.use_acc = (low == SEL_ACC);
            end
            2'b11: begin
                if (low == 3'b110) begin
                    d.cls     = CL_ALU;
                    d.use_acc = 1'b0;
                end
            end
            2'b00: begin
                unique case (low)
                    3'b100, 3'b101: begin
                        d.cls     = (low[0]) ? CL_DEC : CL_INC;
                        d.sel     = mid;
                        d.use_acc = (mid == SEL_ACC);
                    end
                    3'b111: begin
                        unique case (mid)
                            3'd0, 3'd1, 3'd2, 3'd3: d.cls = CL_ROT;
                            3'd4:                   d.cls = CL_DAA;
                            3'd6:                   d.cls = CL_SETC;
                            3'd7:                   d.cls = CL_CPLC;
                            default:                d.cls = CL_NONE;
                        endcase
                    end
                    default: d.cls = CL_NONE;
                endcase
            end
            default: d.cls = CL_NONE;
        endcase
    end
endmodule

// File: rtl/acc_alu_exec.sv
module acc_alu_exec
    import acc_alu_pkg::*;
(
    input  cls_e          cls,
    input  alu_op_e       op,
    input  rot_e          rot,
    input  logic          use_acc,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b_in,
    input  flags_t        f,
    output logic [DW-1:0] res,
    output flags_t        nf
);
    logic [DW-1:0] b;
    logic [DW:0]   wide;
    logic [NW:0]   nib;
    logic [DW:0]   stage;
    logic          cin;
    logic          lo_adj;
    logic          hi_adj;

    assign b = use_acc ? a : b_in;

    always_comb begin
        res    = a;
        nf     = f;
        wide   = '0;
        nib    = '0;
        stage  = '0;
        cin    = 1'b0;
        lo_adj = 1'b0;
        hi_adj = 1'b0;
        case (cls)
            CL_ALU: begin
                case (op)
                    OP_ADD, OP_ADC: begin
                        cin   = (op == OP_ADC) & f.cy;
                        wide  = {1'b0, a} + {1'b0, b} + (DW+1)'(cin);
                        nib   = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + (NW+1)'(cin);
                        res   = wide[DW-1:0];
                        nf.cy = wide[DW];
                        nf.ac = nib[NW];
                    end
                    OP_SUB, OP_SBB, OP_CMP: begin
                        cin   = (op == OP_SBB) & f.cy;
                        wide  = {1'b0, a} - {1'b0, b} - (DW+1)'(cin);
                        nib   = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - (NW+1)'(cin);
                        res   = wide[DW-1:0];
                        nf.cy = wide[DW];
                        nf.ac = nib[NW];
                    end
                    default: begin
                        case (op)
                            OP_AND:  res = a & b;
                            OP_XOR:  res = a ^ b;
                            default: res = a | b;
                        endcase
                        nf.cy = 1'b0;
                        nf.ac = 1'b0;
                    end
                endcase
            end
            CL_INC: begin
                wide  = {1'b0, b} + 9'd1;
                nib   = {1'b0, b[NW-1:0]} + 5'd1;
                res   = wide[DW-1:0];
                nf.ac = nib[NW];
            end
            CL_DEC: begin
                wide  = {1'b0, b} - 9'd1;
                nib   = {1'b0, b[NW-1:0]} - 5'd1;
                res   = wide[DW-1:0];
                nf.ac = nib[NW];
            end
            CL_ROT: begin
                case (rot)
                    RT_LC: begin res = {a[DW-2:0], a[DW-1]}; nf.cy = a[DW-1]; end
                    RT_RC: begin res = {a[0], a[DW-1:1]};    nf.cy = a[0];    end
                    RT_AL: begin res = {a[DW-2:0], f.cy};    nf.cy = a[DW-1]; end
                    default: begin res = {f.cy, a[DW-1:1]};  nf.cy = a[0];    end
                endcase
            end
            CL_DAA: begin
                lo_adj = (a[NW-1:0] > BCD_MAX) | f.ac;
                nib    = {1'b0, a[NW-1:0]} + (lo_adj ? 5'd6 : 5'd0);
                stage  = {1'b0, a} + (lo_adj ? {1'b0, LO_FIX} : 9'd0);
                hi_adj = (stage[DW-1:NW] > BCD_MAX) | f.cy | stage[DW];
                wide   = {1'b0, stage[DW-1:0]} + (hi_adj ? {1'b0, HI_FIX} : 9'd0);
                res    = wide[DW-1:0];
                nf.ac  = nib[NW];
                nf.cy  = f.cy | stage[DW] | wide[DW];
            end
            CL_SETC: nf.cy = 1'b1;
            CL_CPLC: nf.cy = ~f.cy;
            default: ;
        endcase
        nf.s = res[DW-1];
        nf.z = (res == '0);
        nf.p = even_ones(res);
    end
endmodule

// File: rtl/acc_alu_flagreg.sv
module acc_alu_flagreg
    import acc_alu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   strb,
    input  flags_t mask,
    input  flags_t nxt,
    output flags_t q
);
    logic [NFL-1:0] merged;

    assign merged = (NFL'(mask) & NFL'(nxt)) | (~NFL'(mask) & NFL'(q));

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (strb) q <= flags_t'(merged);
    end

    // R12: no strobe, no change
    a_r12_hold: assert property (@(posedge clk) disable iff (rst)
        !strb |=> $stable(q));

    // R9 and R10: carry-only classes leave the other four flags alone
    a_r9_cy_only: assert property (@(posedge clk) disable iff (rst)
        (strb && !mask.s && !mask.z && !mask.ac && !mask.p)
        |=> ({q.s, q.z, q.ac, q.p} == $past({q.s, q.z, q.ac, q.p})));

    // R8: increment and decrement keep carry
    a_r8_keep_cy: assert property (@(posedge clk) disable iff (rst)
        (strb && !mask.cy) |=> (q.cy == $past(q.cy)));
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] opcode,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] operand,
    input  logic          flag_strobe,
    output logic [DW-1:0] res_out,
    output logic          acc_we,
    output logic          oth_we,
    output logic          op_ok,
    output logic [DW-1:0] flags_out
);
    dec_t   dec;
    flags_t cur_f;
    flags_t nxt_f;
    flags_t upd_m;
    logic   is_step;

    acc_alu_decode u_dec (
        .op (opcode),
        .d  (dec)
    );

    acc_alu_exec u_exec (
        .cls     (dec.cls),
        .op      (dec.op),
        .rot     (dec.rot),
        .use_acc (dec.use_acc),
        .a       (acc_in),
        .b_in    (operand),
        .f       (cur_f),
        .res     (res_out),
        .nf      (nxt_f)
    );

    assign upd_m = mask_for(dec.cls);

    acc_alu_flagreg u_flags (
        .clk  (clk),
        .rst  (rst),
        .strb (flag_strobe),
        .mask (upd_m),
        .nxt  (nxt_f),
        .q    (cur_f)
    );

    assign is_step   = (dec.cls == CL_INC) || (dec.cls == CL_DEC);
    assign op_ok     = (dec.cls != CL_NONE);
    assign oth_we    = is_step && (dec.sel != SEL_ACC);
    assign acc_we    = ((dec.cls == CL_ALU) && (dec.op != OP_CMP))
                     || (dec.cls == CL_ROT) || (dec.cls == CL_DAA)
                     || (is_step && (dec.sel == SEL_ACC));
    assign flags_out = pack_flags(cur_f);

    always_comb begin
        if (!rst) begin
            // R7: compare never writes the accumulator
            a_r7_cmp_nowrite: assert (!(opcode[7:6] == 2'b10 && opcode[5:3] == 3'd7) || !acc_we);
            // R8: a result has at most one destination
            a_r8_we_excl: assert (!(acc_we && oth_we));
            // R6: logical results leave carry and auxiliary carry clear
            a_r6_logic_clr: assert (!(dec.cls == CL_ALU && (dec.op == OP_AND || dec.op == OP_XOR || dec.op == OP_OR))
                                    || (!nxt_f.cy && !nxt_f.ac));
            // R13: unknown opcodes raise no write
            a_r13_no_write: assert (op_ok || (!acc_we && !oth_we));
        end
    end
endmodule

// File: tb/tb_acc_alu_core.sv
module tb_acc_alu_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] opcode = '0;
    logic [7:0] acc_in = '0;
    logic [7:0] operand = '0;
    logic       flag_strobe = 1'b0;
    logic [7:0] res_out;
    logic       acc_we;
    logic       oth_we;
    logic       op_ok;
    logic [7:0] flags_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0] c_res;
    logic       c_we, c_ow, c_ok;
    logic [7:0] c_fpre;

    always #4 clk = ~clk;

    acc_alu_core dut (
        .clk         (clk),
        .rst         (rst),
        .opcode      (opcode),
        .acc_in      (acc_in),
        .operand     (operand),
        .flag_strobe (flag_strobe),
        .res_out     (res_out),
        .acc_we      (acc_we),
        .oth_we      (oth_we),
        .op_ok       (op_ok),
        .flags_out   (flags_out)
    );

    // {opcode, acc, operand, carry before, result, acc_we, oth_we, op_ok, flag byte after}
    localparam int NV = 37;
    localparam logic [43:0] VEC [NV] = '{
        {8'h80, 8'h3A, 8'h26, 1'b0, 8'h60, 1'b1, 1'b0, 1'b1, 8'h16},
        {8'h89, 8'hFF, 8'h00, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 8'h57},
        {8'h92, 8'h10, 8'h01, 1'b0, 8'h0F, 1'b1, 1'b0, 1'b1, 8'h16},
        {8'h9B, 8'h05, 8'h05, 1'b1, 8'hFF, 1'b1, 1'b0, 1'b1, 8'h97},
        {8'hA4, 8'hF0, 8'h3C, 1'b1, 8'h30, 1'b1, 1'b0, 1'b1, 8'h06},
        {8'hAD, 8'hAA, 8'h0F, 1'b0, 8'hA5, 1'b1, 1'b0, 1'b1, 8'h86},
        {8'hB6, 8'h01, 8'h02, 1'b0, 8'h03, 1'b1, 1'b0, 1'b1, 8'h06},
        {8'hB8, 8'h20, 8'h30, 1'b0, 8'hF0, 1'b0, 1'b0, 1'b1, 8'h87},
        {8'hFE, 8'h42, 8'h42, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h46},
        {8'hC6, 8'h7F, 8'h01, 1'b0, 8'h80, 1'b1, 1'b0, 1'b1, 8'h92},
        {8'hD6, 8'h00, 8'h01, 1'b0, 8'hFF, 1'b1, 1'b0, 1'b1, 8'h97},
        {8'hF6, 8'h00, 8'h00, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 8'h46},
        {8'hCE, 8'h10, 8'h20, 1'b1, 8'h31, 1'b1, 1'b0, 1'b1, 8'h02},
        {8'hE6, 8'hFF, 8'h81, 1'b0, 8'h81, 1'b1, 1'b0, 1'b1, 8'h86},
        {8'hEE, 8'h55, 8'h55, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h46},
        {8'hDE, 8'h80, 8'h7F, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 8'h56},
        {8'h87, 8'h44, 8'h99, 1'b0, 8'h88, 1'b1, 1'b0, 1'b1, 8'h86},
        {8'h04, 8'h00, 8'h0F, 1'b1, 8'h10, 1'b0, 1'b1, 1'b1, 8'h13},
        {8'h0D, 8'h00, 8'h01, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 8'h47},
        {8'h3D, 8'h00, 8'h55, 1'b0, 8'hFF, 1'b1, 1'b0, 1'b1, 8'h96},
        {8'h3C, 8'hFF, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h56},
        {8'h34, 8'h00, 8'h7F, 1'b0, 8'h80, 1'b0, 1'b1, 1'b1, 8'h92},
        {8'h07, 8'h81, 8'h00, 1'b0, 8'h03, 1'b1, 1'b0, 1'b1, 8'h47},
        {8'h0F, 8'h01, 8'h00, 1'b0, 8'h80, 1'b1, 1'b0, 1'b1, 8'h47},
        {8'h17, 8'h80, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h47},
        {8'h1F, 8'h02, 8'h00, 1'b1, 8'h81, 1'b1, 1'b0, 1'b1, 8'h46},
        {8'h17, 8'h01, 8'h00, 1'b1, 8'h03, 1'b1, 1'b0, 1'b1, 8'h46},
        {8'h37, 8'h5A, 8'h00, 1'b0, 8'h5A, 1'b0, 1'b0, 1'b1, 8'h47},
        {8'h3F, 8'h5A, 8'h00, 1'b1, 8'h5A, 1'b0, 1'b0, 1'b1, 8'h46},
        {8'h3F, 8'h5A, 8'h00, 1'b0, 8'h5A, 1'b0, 1'b0, 1'b1, 8'h47},
        {8'h27, 8'h9B, 8'h00, 1'b0, 8'h01, 1'b1, 1'b0, 1'b1, 8'h13},
        {8'h27, 8'h15, 8'h00, 1'b1, 8'h75, 1'b1, 1'b0, 1'b1, 8'h03},
        {8'h27, 8'h42, 8'h00, 1'b0, 8'h42, 1'b1, 1'b0, 1'b1, 8'h06},
        {8'h00, 8'h33, 8'h00, 1'b1, 8'h33, 1'b0, 1'b0, 1'b0, 8'h47},
        {8'h76, 8'h33, 8'h00, 1'b0, 8'h33, 1'b0, 1'b0, 1'b0, 8'h46},
        {8'h2F, 8'h33, 8'h00, 1'b0, 8'h33, 1'b0, 1'b0, 1'b0, 8'h46},
        {8'h9F, 8'h10, 8'h00, 1'b1, 8'hFF, 1'b1, 1'b0, 1'b1, 8'h97}
    };

    function automatic string tag_for(input logic [7:0] o);
        if (o[7:6] == 2'b10) begin
            if (o[5:3] == 3'd7)      return "R7 R5";
            if (o[2:0] == 3'd7)      return "R2 R4 R5";
            if (o[5])                return "R6 R2 R5";
            return "R4 R2 R5";
        end
        if (o[7:6] == 2'b11)         return "R3 R4 R6 R5";
        if (o == 8'h27)              return "R11";
        if (o == 8'h37 || o == 8'h3F) return "R10";
        if (o[7:6] == 2'b00 && o[2:0] == 3'b111 && !o[5]) return "R9";
        if (o[7:6] == 2'b00 && o[2:1] == 2'b10) return "R8 R5";
        return "R13";
    endfunction

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge with the strobe low
    task automatic step(input logic [7:0] o, input logic [7:0] a, input logic [7:0] b, input logic s);
        opcode = o;
        acc_in = a;
        operand = b;
        flag_strobe = s;
        #1;
        c_res  = res_out;
        c_we   = acc_we;
        c_ow   = oth_we;
        c_ok   = op_ok;
        c_fpre = flags_out;
        @(posedge clk);
        @(negedge clk);
        flag_strobe = 1'b0;
    endtask

    task automatic prep(input logic cy);
        step(8'hAF, 8'h00, 8'h00, 1'b1);
        if (cy) step(8'h37, 8'h00, 8'h00, 1'b1);
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state of the flag byte
        chk("R1", "flags after reset", flags_out, 8'h02);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [43:0] v;
            v = VEC[i];
            prep(v[19]);
            step(v[43:36], v[35:28], v[27:20], 1'b1);
            chk(tag_for(v[43:36]), "res_out", c_res, v[18:11]);
            chk(tag_for(v[43:36]), "acc_we", {7'd0, c_we}, {7'd0, v[10]});
            chk(tag_for(v[43:36]), "oth_we", {7'd0, c_ow}, {7'd0, v[9]});
            chk(tag_for(v[43:36]), "op_ok", {7'd0, c_ok}, {7'd0, v[8]});
            chk(tag_for(v[43:36]), "flags", flags_out, v[7:0]);
        end

        // R12: strobe low leaves flags, result still combinational
        prep(1'b0);
        step(8'h80, 8'h7F, 8'h01, 1'b0);
        chk("R12", "res without strobe", c_res, 8'h80);
        chk("R12", "flags without strobe", flags_out, 8'h46);

        // R12: flags hold before the edge and change after it
        step(8'h80, 8'h7F, 8'h01, 1'b1);
        chk("R12", "flags before edge", c_fpre, 8'h46);
        chk("R12", "flags after edge", flags_out, 8'h92);

        // R11: auxiliary carry from a previous add drives the low correction
        prep(1'b0);
        step(8'h80, 8'h09, 8'h08, 1'b1);
        chk("R11", "add before adjust flags", flags_out, 8'h16);
        step(8'h27, 8'h11, 8'h00, 1'b1);
        chk("R11", "adjust with ac", c_res, 8'h17);
        chk("R11", "flags after adjust", flags_out, 8'h06);

        // R13: strobe on an unknown opcode after a carry-set state
        prep(1'b1);
        step(8'hC3, 8'h12, 8'h34, 1'b1);
        chk("R13", "unknown op result", c_res, 8'h12);
        chk("R13", "unknown op flags", flags_out, 8'h47);

        // R1: reset in the middle of a run
        step(8'h9B, 8'h05, 8'h05, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "flags after mid-run reset", flags_out, 8'h02);

        done = 1;
        summary();
        $finish;
    end
endmodule